// File: doc/BRIEF.md
# Supervisory Reset Delay Generator

This block turns two fault indications into one clean system reset. The first is a supply-good flag: a digital signal that an external comparator with hysteresis has already derived from the monitored rail. The second is a manual reset request from a push-button or another controller, which is active low and asynchronous to the block clock. While either source is active, the block holds its reset outputs asserted. Once both sources are inactive, it keeps the reset asserted for a fixed hold-off before it releases it.

The hold-off is counted in cycles of a free-running clock and is set by a parameter. A typical setting is a count equal to about 200 ms at the clock rate in use. Any new fault during the hold-off clears the count. The full hold-off then starts again once the last source has gone inactive. The supply path and the manual path share one counter, so the release delay is the same whichever source caused the reset. Two reset outputs are driven, one active low and one active high. Both come from registers and are always exact complements of each other.

Top module: `sys_rst_gen`

## Requirements
- R1: Whenever `rst` is high at a rising clock edge, after that edge `rst_out_n` is 0 and `rst_out` is 1, and the hold-off count is cleared. After `rst` falls, with both sources inactive, the reset is released after exactly `DELAY_CYCLES` further edges.
- R2: If `supply_ok` is 0 at a rising edge, `rst_out_n` is 0 right after that edge (one cycle of latency).
- R3: If `man_req_n` is 0 (a low level means a request), `rst_out_n` is 0 no later than after the third rising edge that samples it. Two of those edges are the synchronizer stages and one is the output register.
- R4: `rst_out_n` rises after exactly `DELAY_CYCLES` consecutive fault-free edges. For a supply fault, counting starts at the first edge that samples `supply_ok` = 1. For a manual request, counting starts two edges after the first edge that samples `man_req_n` = 1.
- R5: A fault from either source during the hold-off clears the count. The release then comes `DELAY_CYCLES` fault-free edges after the new fault ends.
- R6: A fall of `supply_ok` after the reset has been released reasserts the reset after the next edge, even for a single-cycle drop.
- R7: `rst_out` is always the logical complement of `rst_out_n`.
- R8: When both sources are active at once, the hold-off is timed from whichever source goes inactive last.
- R9: Once released, the reset stays deasserted for as long as both sources stay inactive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock that times the hold-off |
| rst | input | 1 | Synchronous active-high initialisation of the block |
| supply_ok | input | 1 | Conditioned supply-good flag, synchronous to clk; 0 = rail below threshold |
| man_req_n | input | 1 | Asynchronous manual reset request, active low |
| rst_out_n | output | 1 | System reset, active low, registered |
| rst_out | output | 1 | System reset, active high, registered complement of rst_out_n |

## Verification
A supply fault is due on the outputs one edge after it is sampled. A manual request is due three edges after it is sampled, because of the two synchronizer flops plus the output register. A release is due `DELAY_CYCLES` edges after the last fault-free start point, which for the manual path is two edges later than for the supply path. The bench drives inputs on falling edges and counts rising edges up to the one due. It checks that the output is still asserted one edge before the due edge and released on the due edge, so an off-by-one in either direction is reported. The checker module bound to the top independently counts fault-free edges, and it flags any release that comes before the full count.

// File: rtl/sys_rst_pkg.sv
package sys_rst_pkg;

  // Hold-off state: reset held, or released to the system.
  typedef enum logic {
    ST_HELD = 1'b0,
    ST_FREE = 1'b1
  } rel_state_t;

  function automatic int cnt_width(input int n);
    return (n > 1) ? $clog2(n) : 1;
  endfunction

endpackage

// File: rtl/sys_rst_sync.sv
module sys_rst_sync #(
  parameter int  STAGES    = 2,
  parameter logic RST_VAL  = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d_async,
  output logic q_sync
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain_q <= {STAGES{RST_VAL}};
    end else begin
      chain_q[0] <= d_async;
      for (int i = 1; i < STAGES; i++) begin
        chain_q[i] <= chain_q[i-1];
      end
    end
  end

  assign q_sync = chain_q[STAGES-1];

endmodule

// File: rtl/sys_rst_holdoff.sv
module sys_rst_holdoff
  import sys_rst_pkg::*;
#(
  parameter int DELAY_CYCLES = 2_000_000
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       fault,
  output rel_state_t state_d
);

  localparam int              CNT_W = cnt_width(DELAY_CYCLES);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY_CYCLES - 1);

  rel_state_t       state_q;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    if (fault) begin
      state_d = ST_HELD;
      cnt_d   = '0;
    end else if (state_q == ST_HELD) begin
      if (cnt_q == LAST) begin
        state_d = ST_FREE;
      end else begin
        cnt_d = cnt_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_HELD;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

endmodule

// File: rtl/sys_rst_drive.sv
module sys_rst_drive
  import sys_rst_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  rel_state_t state_d,
  output logic       rst_out_n,
  output logic       rst_out
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rst_out_n <= 1'b0;
      rst_out   <= 1'b1;
    end else begin
      rst_out_n <= (state_d == ST_FREE);
      rst_out   <= (state_d == ST_HELD);
    end
  end

endmodule

// File: rtl/sys_rst_gen.sv
module sys_rst_gen
  import sys_rst_pkg::*;
#(
  parameter int DELAY_CYCLES = 2_000_000,
  parameter int SYNC_STAGES  = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic supply_ok,
  input  logic man_req_n,
  output logic rst_out_n,
  output logic rst_out
);

  logic       man_sync;
  logic       fault;
  rel_state_t state_d;

  sys_rst_sync #(
    .STAGES  (SYNC_STAGES),
    .RST_VAL (1'b1)
  ) u_man_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async (man_req_n),
    .q_sync  (man_sync)
  );

  assign fault = !supply_ok || !man_sync;

  sys_rst_holdoff #(
    .DELAY_CYCLES (DELAY_CYCLES)
  ) u_holdoff (
    .clk     (clk),
    .rst     (rst),
    .fault   (fault),
    .state_d (state_d)
  );

  sys_rst_drive u_drive (
    .clk       (clk),
    .rst       (rst),
    .state_d   (state_d),
    .rst_out_n (rst_out_n),
    .rst_out   (rst_out)
  );

endmodule

// File: rtl/sys_rst_gen_chk.sv
module sys_rst_gen_chk #(
  parameter int DELAY_CYCLES = 2_000_000
) (
  input logic clk,
  input logic rst,
  input logic supply_ok,
  input logic man_sync,
  input logic rst_out_n,
  input logic rst_out
);

  localparam int QW = $clog2(DELAY_CYCLES + 1);

  // Independent count of consecutive fault-free edges, saturating.
  logic [QW-1:0] quiet_q;

  always_ff @(posedge clk) begin
    if (rst || !supply_ok || !man_sync) begin
      quiet_q <= '0;
    end else if (quiet_q < QW'(DELAY_CYCLES)) begin
      quiet_q <= quiet_q + 1'b1;
    end
  end

  assert_complement_R7: assert property (@(posedge clk) disable iff (rst)
    rst_out == !rst_out_n);

  assert_supply_fault_R2: assert property (@(posedge clk) disable iff (rst)
    !supply_ok |=> !rst_out_n);

  assert_manual_fault_R3: assert property (@(posedge clk) disable iff (rst)
    !man_sync |=> !rst_out_n);

  assert_full_holdoff_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(rst_out_n) |-> (quiet_q >= QW'(DELAY_CYCLES)));

  assert_stay_released_R9: assert property (@(posedge clk) disable iff (rst)
    (rst_out_n && supply_ok && man_sync) |=> rst_out_n);

endmodule

bind sys_rst_gen sys_rst_gen_chk #(
  .DELAY_CYCLES (DELAY_CYCLES)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .supply_ok (supply_ok),
  .man_sync  (man_sync),
  .rst_out_n (rst_out_n),
  .rst_out   (rst_out)
);

// File: tb/sys_rst_gen_tb.sv
module sys_rst_gen_tb;

  localparam int CLK_PERIOD = 10;
  localparam int D          = 20;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic supply_ok = 1'b1;
  logic man_req_n = 1'b1;
  logic rst_out_n, rst_out;

  int  n_checks = 0;
  int  n_fails  = 0;
  bit  finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sys_rst_gen #(.DELAY_CYCLES(D)) u_dut (
    .clk       (clk),
    .rst       (rst),
    .supply_ok (supply_ok),
    .man_req_n (man_req_n),
    .rst_out_n (rst_out_n),
    .rst_out   (rst_out)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // exp_rel: 1 = reset released; also checks the complement (R7)
  task automatic check(input string req, input logic exp_rel);
    n_checks++;
    if (rst_out_n !== exp_rel) begin
      n_fails++;
      $display("FAIL %s: rst_out_n=%b expected %b at %0t", req, rst_out_n, exp_rel, $time);
    end
    n_checks++;
    if (rst_out !== ~exp_rel) begin
      n_fails++;
      $display("FAIL R7 (%s): rst_out=%b expected %b at %0t", req, rst_out, ~exp_rel, $time);
    end
  endtask

  task automatic test_init_R1;
    rst = 1'b1;
    tick(3);
    check("R1 reset state", 1'b0);
    rst = 1'b0;
    tick(D - 1);
    check("R1 held before delay", 1'b0);
    tick(1);
    check("R1 released after delay", 1'b1);
  endtask

  task automatic test_supply_R2_R4;
    supply_ok = 1'b0;
    tick(1);
    check("R2 supply fault one edge", 1'b0);
    tick(5);
    supply_ok = 1'b1;
    tick(D - 1);
    check("R4 supply held D-1", 1'b0);
    tick(1);
    check("R4 supply release at D", 1'b1);
  endtask

  task automatic test_manual_R3_R4;
    man_req_n = 1'b0;
    tick(2);
    check("R3 manual not yet after 2 edges", 1'b1);
    tick(1);
    check("R3 manual asserted after 3 edges", 1'b0);
    tick(5);
    man_req_n = 1'b1;
    tick(D + 1);
    check("R4 manual held D+1", 1'b0);
    tick(1);
    check("R4 manual release at D+2", 1'b1);
  endtask

  task automatic test_restart_R5;
    supply_ok = 1'b0;
    tick(3);
    supply_ok = 1'b1;
    tick(10);
    check("R5 counting midway", 1'b0);
    supply_ok = 1'b0;
    tick(1);
    supply_ok = 1'b1;
    tick(D - 1);
    check("R5 restarted, held D-1", 1'b0);
    tick(1);
    check("R5 restarted, release at D", 1'b1);
  endtask

  task automatic test_overlap_R8;
    supply_ok = 1'b0;
    man_req_n = 1'b0;
    tick(4);
    supply_ok = 1'b1;
    tick(D + 5);
    check("R8 manual still active", 1'b0);
    man_req_n = 1'b1;
    tick(D + 1);
    check("R8 held until last source D+1", 1'b0);
    tick(1);
    check("R8 release from last source", 1'b1);
  endtask

  task automatic test_glitch_R6;
    supply_ok = 1'b0;
    tick(1);
    check("R6 single-cycle drop reasserts", 1'b0);
    supply_ok = 1'b1;
    tick(D - 1);
    check("R6 held after drop", 1'b0);
    tick(1);
    check("R6 release after drop", 1'b1);
  endtask

  task automatic test_stable_R9;
    for (int i = 0; i < 30; i++) begin
      tick(1);
      check("R9 stays released", 1'b1);
    end
  endtask

  task automatic test_midrun_reset_R1;
    rst = 1'b1;
    tick(1);
    check("R1 reset while released", 1'b0);
    rst = 1'b0;
    tick(D - 1);
    check("R1 held after mid-run reset", 1'b0);
    tick(1);
    check("R1 release after mid-run reset", 1'b1);
  endtask

  task automatic summary;
    if (!finished) begin
      finished = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    tick(1);
    test_init_R1();
    test_supply_R2_R4();
    test_manual_R3_R4();
    test_restart_R5();
    test_overlap_R8();
    test_glitch_R6();
    test_stable_R9();
    test_midrun_reset_R1();
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_checks++;
    n_fails++;
    $display("FAIL watchdog: run did not complete, actual hung expected done");
    summary();
  end

endmodule